// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block collects the per-channel event pulses of a multi-channel DMA controller and sorts them into four event classes: transfer complete, source-side error, destination-side error and configuration error. For each class it keeps a raw register with one bit per channel. Each raw bit is set by an event and cleared by software writing a 1 to it. It also gives a masked view of each class. A masked bit shows a raw bit only when that channel's two interrupt-enable bits are both set.

Software reaches the registers through a simple read/write port. The same port gives access to a live busy vector, one bit per channel, and to two configuration registers, group priority and arbitration. Both configuration registers drive the channel engines. When the arbitration register holds zero, every channel has the same priority. A single interrupt line is high while any masked bit of any class is set.

Top module: `dmairq_status_unit`

## Requirements
- R1: After reset every raw and masked bit is 0, group priority and arbitration read 0, `irq` is low and `reg_rdata` is 0.
- R2: An event pulse on channel i of a class sets bit i of that class's raw register on the clock edge that samples it. The raw registers are at 0x810 (complete), 0x814 (source error), 0x818 (destination error) and 0x81C (configuration error).
- R3: A write to a raw register clears each bit written as 1. Bits written as 0 keep their value.
- R4: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: The masked registers are at 0x800, 0x804, 0x808 and 0x80C, in the same class order as the raw registers. Bit i of a masked register is raw bit i AND `ch_ien_a[i]` AND `ch_ien_b[i]`.
- R6: `irq` is the OR of every bit of all four masked registers. It follows a raw change in the same cycle the raw bit changes.
- R7: Writes to the masked registers (0x800 to 0x80C) and to the busy register (0x820) change no state.
- R8: A read of 0x820 returns `ch_busy` as sampled on the read edge, with bit i belonging to channel i.
- R9: Group priority (0x824, PRIO_W bits) and arbitration (0x828, ARB_W bits) are read/write and drive `grp_prio` and `arb_cfg`. `arb_equal` is high exactly when the arbitration register is 0.
- R10: `reg_rdata` is loaded on the edge where `reg_rd` is high, with the register values from before that edge. It holds its value otherwise. Unmapped offsets and bits above the register width read 0.
- R11: A raw bit that sees no event keeps its value until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_done | input | NCH | Per-channel transfer-complete pulses |
| evt_src_err | input | NCH | Per-channel source error pulses |
| evt_dst_err | input | NCH | Per-channel destination error pulses |
| evt_cfg_err | input | NCH | Per-channel configuration error pulses |
| ch_ien_a | input | NCH | First interrupt-enable bit of each channel's active control word |
| ch_ien_b | input | NCH | Second interrupt-enable bit of each channel's active control word |
| ch_busy | input | NCH | Per-channel running flags |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Combined interrupt |
| grp_prio | output | PRIO_W | Group priority setting |
| arb_cfg | output | ARB_W | Arbitration setting |
| arb_equal | output | 1 | High when all channels share one priority |

## Verification
The bench goes after an event landing in the same cycle as a write-1 clear of that bit. A design that let the clear win would lose a completion. It checks that a 0 in the clear data preserves a bit, which catches a design that writes the raw register instead of clearing it. It checks that writes to masked or busy offsets leave the raw registers untouched, which catches a decoder that aliases them. Clearing only one of the two enable bits per channel exposes a mask that ORs the enables instead of ANDing them. Reads at unmapped offsets and the upper-bit check catch a read multiplexer that leaks stale or shifted data.

// File: rtl/dmairq_pkg.sv
// Package: register offsets and event-class numbering shared by the
// interrupt status unit and its submodules.
// Assumes byte addressing with 32-bit register spacing.
package dmairq_pkg;

    localparam int NCLS = 4;

    typedef enum logic [1:0] {
        CLS_DONE = 2'd0,
        CLS_SERR = 2'd1,
        CLS_DERR = 2'd2,
        CLS_CERR = 2'd3
    } evt_class_e;

    localparam logic [11:0] OFS_MASK_BASE = 12'h800;
    localparam logic [11:0] OFS_RAW_BASE  = 12'h810;
    localparam logic [11:0] OFS_BUSY      = 12'h820;
    localparam logic [11:0] OFS_PRIO      = 12'h824;
    localparam logic [11:0] OFS_ARB       = 12'h828;
    localparam logic [11:0] OFS_STRIDE    = 12'h004;

endpackage

// File: rtl/dmairq_class_bank.sv
// Module: one event class. Holds the raw per-channel bits, with
// set-by-event and write-1-to-clear, and forms the enable-gated view.
// Assumes clr is already decoded for this class's raw offset.
module dmairq_class_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt,
    input  logic [NCH-1:0] clr,
    input  logic [NCH-1:0] en,
    output logic [NCH-1:0] raw,
    output logic [NCH-1:0] masked
);

    logic [NCH-1:0] raw_nxt;

    // Next raw value: clear first, then the event wins over the clear.
    always_comb begin
        raw_nxt = (raw & ~clr) | evt;
    end

    // Raw state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) raw <= '0;
        else        raw <= raw_nxt;
    end

    // Masked view gated by the per-channel enable.
    always_comb begin
        masked = raw & en;
    end

    // R4 / R2: every sampled event shows in raw after the edge.
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & $past(evt)) == $past(evt)));

    // R3: a clear with no coincident event leaves the bit at zero.
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & $past(clr & ~evt)) == '0));

    // R11: no bit rises without an event.
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & ~$past(raw | evt)) == '0));

endmodule

// File: rtl/dmairq_cfg_regs.sv
// Module: group-priority and arbitration registers.
// Assumes the write strobes are already decoded; the arbitration value
// zero means every channel gets the same priority.
module dmairq_cfg_regs #(
    parameter int DATA_W = 32,
    parameter int PRIO_W = 8,
    parameter int ARB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_prio,
    input  logic              wr_arb,
    input  logic [DATA_W-1:0] wdata,
    output logic [PRIO_W-1:0] prio,
    output logic [ARB_W-1:0]  arb,
    output logic              arb_equal
);

    // Group priority register.
    always_ff @(posedge clk) begin
        if (!rst_n)       prio <= '0;
        else if (wr_prio) prio <= wdata[PRIO_W-1:0];
    end

    // Arbitration register.
    always_ff @(posedge clk) begin
        if (!rst_n)      arb <= '0;
        else if (wr_arb) arb <= wdata[ARB_W-1:0];
    end

    // Equal-priority flag for the channel arbiter.
    always_comb begin
        arb_equal = (arb == '0);
    end

    // R9: the arbitration value changes only on its own write.
    a_r9_arb_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_arb |=> $stable(arb));

    // R9: the priority value changes only on its own write.
    a_r9_prio_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_prio |=> $stable(prio));

endmodule

// File: rtl/dmairq_read_mux.sv
// Module: registered read path. Decodes the offset, picks a raw, masked,
// busy or configuration value and zero-extends it.
// Assumes unmapped offsets read zero.
module dmairq_read_mux #(
    parameter int NCH    = 8,
    parameter int NCLS   = 4,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PRIO_W = 8,
    parameter int ARB_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NCLS-1:0][NCH-1:0]  raw_all,
    input  logic [NCLS-1:0][NCH-1:0]  masked_all,
    input  logic [NCH-1:0]            busy,
    input  logic [PRIO_W-1:0]         prio,
    input  logic [ARB_W-1:0]          arb,
    output logic [DATA_W-1:0]         rdata
);
    import dmairq_pkg::*;

    logic [DATA_W-1:0] sel_data;

    // Offset decode and zero-extension of the selected register.
    always_comb begin
        sel_data = '0;
        for (int c = 0; c < NCLS; c++) begin
            if (addr == ADDR_W'(OFS_MASK_BASE + OFS_STRIDE * 12'(c)))
                sel_data = DATA_W'(masked_all[c]);
            if (addr == ADDR_W'(OFS_RAW_BASE + OFS_STRIDE * 12'(c)))
                sel_data = DATA_W'(raw_all[c]);
        end
        if (addr == ADDR_W'(OFS_BUSY)) sel_data = DATA_W'(busy);
        if (addr == ADDR_W'(OFS_PRIO)) sel_data = DATA_W'(prio);
        if (addr == ADDR_W'(OFS_ARB))  sel_data = DATA_W'(arb);
    end

    // Read data register, loaded only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= sel_data;
    end

    // R10: read data holds between reads.
    a_r10_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

endmodule

// File: rtl/dmairq_status_unit.sv
// Module: top of the DMA interrupt status unit. Decodes register writes
// into per-class clear vectors, builds one bank per event class, the
// configuration registers and the read path, and ORs the masked bits
// into the interrupt line.
// Assumes NCH <= DATA_W, PRIO_W <= DATA_W and ARB_W <= DATA_W.
module dmairq_status_unit #(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int PRIO_W = 8,
    parameter int ARB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    evt_done,
    input  logic [NCH-1:0]    evt_src_err,
    input  logic [NCH-1:0]    evt_dst_err,
    input  logic [NCH-1:0]    evt_cfg_err,
    input  logic [NCH-1:0]    ch_ien_a,
    input  logic [NCH-1:0]    ch_ien_b,
    input  logic [NCH-1:0]    ch_busy,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic [PRIO_W-1:0] grp_prio,
    output logic [ARB_W-1:0]  arb_cfg,
    output logic              arb_equal
);
    import dmairq_pkg::*;

    logic [NCLS-1:0][NCH-1:0] evt_all;
    logic [NCLS-1:0][NCH-1:0] clr_all;
    logic [NCLS-1:0][NCH-1:0] raw_all;
    logic [NCLS-1:0][NCH-1:0] masked_all;
    logic [NCH-1:0]           ch_en;
    logic                     wr_prio;
    logic                     wr_arb;

    // Gather the class inputs in register order.
    always_comb begin
        evt_all[CLS_DONE] = evt_done;
        evt_all[CLS_SERR] = evt_src_err;
        evt_all[CLS_DERR] = evt_dst_err;
        evt_all[CLS_CERR] = evt_cfg_err;
    end

    // Both enable bits of a channel are needed.
    always_comb begin
        ch_en = ch_ien_a & ch_ien_b;
    end

    // Configuration write decode.
    always_comb begin
        wr_prio = reg_wr && (reg_addr == ADDR_W'(OFS_PRIO));
        wr_arb  = reg_wr && (reg_addr == ADDR_W'(OFS_ARB));
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        localparam logic [11:0] RAW_OFS = OFS_RAW_BASE + OFS_STRIDE * 12'(c);

        // Write-1-to-clear vector for this class.
        always_comb begin
            clr_all[c] = (reg_wr && (reg_addr == ADDR_W'(RAW_OFS)))
                         ? reg_wdata[NCH-1:0] : '0;
        end

        dmairq_class_bank #(.NCH(NCH)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_all[c]),
            .clr    (clr_all[c]),
            .en     (ch_en),
            .raw    (raw_all[c]),
            .masked (masked_all[c])
        );

        // R7: a write to this class's masked offset never alters raw state.
        a_r7_mask_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && (reg_addr == ADDR_W'(OFS_MASK_BASE + OFS_STRIDE * 12'(c)))
             && (evt_all[c] == '0)) |=> $stable(raw_all[c]));
    end

    dmairq_cfg_regs #(
        .DATA_W (DATA_W),
        .PRIO_W (PRIO_W),
        .ARB_W  (ARB_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_prio   (wr_prio),
        .wr_arb    (wr_arb),
        .wdata     (reg_wdata),
        .prio      (grp_prio),
        .arb       (arb_cfg),
        .arb_equal (arb_equal)
    );

    dmairq_read_mux #(
        .NCH    (NCH),
        .NCLS   (NCLS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PRIO_W (PRIO_W),
        .ARB_W  (ARB_W)
    ) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (reg_rd),
        .addr       (reg_addr),
        .raw_all    (raw_all),
        .masked_all (masked_all),
        .busy       (ch_busy),
        .prio       (grp_prio),
        .arb        (arb_cfg),
        .rdata      (reg_rdata)
    );

    // Combined interrupt over every masked bit.
    always_comb begin
        irq = |masked_all;
    end

    // R6: with no channel enabled the line stays low.
    a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0) |-> !irq);

    // R6: an enabled pending completion always raises the line.
    a_r6_irq_live: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_all[CLS_DONE] & ch_ien_a & ch_ien_b) != '0) |-> irq);

endmodule

// File: tb/dmairq_status_unit_tb.sv
module dmairq_status_unit_tb;
    localparam int NCH = 8, ADDR_W = 12, DATA_W = 32, PRIO_W = 8, ARB_W = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NCH-1:0]    evt_done, evt_src_err, evt_dst_err, evt_cfg_err;
    logic [NCH-1:0]    ch_ien_a, ch_ien_b, ch_busy;
    logic [ADDR_W-1:0] reg_addr;
    logic              reg_wr, reg_rd;
    logic [DATA_W-1:0] reg_wdata;
    logic [DATA_W-1:0] reg_rdata;
    logic              irq;
    logic [PRIO_W-1:0] grp_prio;
    logic [ARB_W-1:0]  arb_cfg;
    logic              arb_equal;

    always #2 clk = ~clk;

    dmairq_status_unit #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                         .PRIO_W(PRIO_W), .ARB_W(ARB_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_done(evt_done), .evt_src_err(evt_src_err),
        .evt_dst_err(evt_dst_err), .evt_cfg_err(evt_cfg_err),
        .ch_ien_a(ch_ien_a), .ch_ien_b(ch_ien_b), .ch_busy(ch_busy),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .grp_prio(grp_prio), .arb_cfg(arb_cfg), .arb_equal(arb_equal));

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Reference model state
    logic [NCH-1:0]    m_raw [4];
    logic [PRIO_W-1:0] m_prio;
    logic [ARB_W-1:0]  m_arb;
    logic [DATA_W-1:0] m_rdata;

    function automatic logic [11:0] addr_of(int k);
        case (k)
            0,1,2,3: return 12'h800 + 12'(4*k);
            4,5,6,7: return 12'h810 + 12'(4*(k-4));
            8:  return 12'h820;
            9:  return 12'h824;
            10: return 12'h828;
            11: return 12'h82C;
            default: return 12'h000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] model_read(logic [11:0] a);
        for (int c = 0; c < 4; c++) begin
            if (a == 12'h800 + 12'(4*c)) return DATA_W'(m_raw[c] & ch_ien_a & ch_ien_b);
            if (a == 12'h810 + 12'(4*c)) return DATA_W'(m_raw[c]);
        end
        if (a == 12'h820) return DATA_W'(ch_busy);
        if (a == 12'h824) return DATA_W'(m_prio);
        if (a == 12'h828) return DATA_W'(m_arb);
        return '0;
    endfunction

    function automatic logic model_irq();
        logic r = 1'b0;
        for (int c = 0; c < 4; c++) r |= |(m_raw[c] & ch_ien_a & ch_ien_b);
        return r;
    endfunction

    function automatic string tag_of(logic [11:0] a);
        if (a >= 12'h800 && a <= 12'h80C) return "R5";
        if (a >= 12'h810 && a <= 12'h81C) return "R3";
        if (a == 12'h820) return "R8";
        if (a == 12'h824 || a == 12'h828) return "R9";
        return "R10";
    endfunction

    task automatic check(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One cycle: model the edge with the inputs already driven, then check.
    task automatic step();
        logic [NCH-1:0] evs [4];
        logic [11:0] a;
        evs[0] = evt_done; evs[1] = evt_src_err; evs[2] = evt_dst_err; evs[3] = evt_cfg_err;
        a = reg_addr;
        if (reg_rd) m_rdata = model_read(a);
        for (int c = 0; c < 4; c++) begin
            logic [NCH-1:0] clr;
            clr = (reg_wr && a == 12'h810 + 12'(4*c)) ? reg_wdata[NCH-1:0] : '0;
            m_raw[c] = (m_raw[c] & ~clr) | evs[c];
        end
        if (reg_wr && a == 12'h824) m_prio = reg_wdata[PRIO_W-1:0];
        if (reg_wr && a == 12'h828) m_arb  = reg_wdata[ARB_W-1:0];
        @(posedge clk); #1;
        check("R6 irq", DATA_W'(irq), DATA_W'(model_irq()));
        if (reg_rd) check(tag_of(a), reg_rdata, m_rdata);
        @(negedge clk);
    endtask

    task automatic idle();
        evt_done = '0; evt_src_err = '0; evt_dst_err = '0; evt_cfg_err = '0;
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic do_read(logic [11:0] a);
        idle(); reg_rd = 1; reg_addr = a; step(); reg_rd = 0;
    endtask

    task automatic do_write(logic [11:0] a, logic [DATA_W-1:0] d);
        idle(); reg_wr = 1; reg_addr = a; reg_wdata = d; step(); reg_wr = 0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        ch_ien_a = '1; ch_ien_b = '1; ch_busy = '0;
        rst_n = 0;
        for (int c = 0; c < 4; c++) m_raw[c] = '0;
        m_prio = '0; m_arb = '0; m_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        check("R1 rdata", reg_rdata, '0);
        check("R1 irq", DATA_W'(irq), '0);
        check("R1 arb_equal", DATA_W'(arb_equal), 32'd1);
        for (int k = 0; k < 11; k++) do_read(addr_of(k));

        // R2 event sets raw bit, R11 holds
        idle(); evt_src_err = 8'h24; step();
        repeat (5) begin idle(); step(); end
        do_read(12'h814);
        check("R2 raw src", reg_rdata, 32'h24);
        check("R11 hold", reg_rdata, 32'h24);

        // R3 partial clear, 0 bits keep
        do_write(12'h814, 32'h04);
        do_read(12'h814);
        check("R3 partial clear", reg_rdata, 32'h20);

        // R4 event coincident with clear
        idle(); evt_src_err = 8'h20; reg_wr = 1; reg_addr = 12'h814; reg_wdata = 32'h20; step();
        do_read(12'h814);
        check("R4 event wins", reg_rdata, 32'h20);

        // R7 writes to masked and busy offsets are inert
        do_write(12'h804, 32'hFF);
        do_write(12'h820, 32'hFF);
        do_read(12'h814);
        check("R7 masked write inert", reg_rdata, 32'h20);

        // R5 only one enable bit cleared hides the channel
        ch_ien_b = 8'hDF;
        do_read(12'h804);
        check("R5 and of enables", reg_rdata, 32'h00);
        check("R6 irq low when masked", DATA_W'(irq), 32'd0);
        ch_ien_b = '1; ch_ien_a = 8'hDF;
        do_read(12'h804);
        check("R5 and of enables a", reg_rdata, 32'h00);
        ch_ien_a = '1;

        // R8 busy, R9 cfg, R10 upper bits and unmapped
        ch_busy = 8'hA5; do_read(12'h820);
        check("R8 busy", reg_rdata, 32'hA5);
        do_write(12'h828, 32'hFFFF_FFF3);
        check("R9 arb_cfg", DATA_W'(arb_cfg), 32'h3);
        check("R9 arb_equal low", DATA_W'(arb_equal), 32'd0);
        do_write(12'h824, 32'h1234_5678);
        check("R9 grp_prio", DATA_W'(grp_prio), 32'h78);
        do_read(12'h824);
        do_read(12'h82C);
        check("R10 unmapped", reg_rdata, 32'h0);
        do_write(12'h828, 32'h0);
        check("R9 arb_equal high", DATA_W'(arb_equal), 32'd1);
        check("R10 rdata holds", reg_rdata, 32'h0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int k;
            idle();
            evt_done    = NCH'($urandom & $urandom & $urandom);
            evt_src_err = NCH'($urandom & $urandom & $urandom & $urandom);
            evt_dst_err = NCH'($urandom & $urandom & $urandom & $urandom);
            evt_cfg_err = NCH'($urandom & $urandom & $urandom & $urandom);
            ch_ien_a = NCH'($urandom | $urandom);
            ch_ien_b = NCH'($urandom | $urandom);
            ch_busy  = NCH'($urandom);
            k = int'($urandom % 13);
            reg_addr = addr_of(k);
            reg_wdata = $urandom;
            reg_wr = ($urandom % 3) == 0;
            reg_rd = ($urandom % 2) == 0;
            step();
        end
        idle();
        for (int k = 0; k < 13; k++) do_read(addr_of(k));

        finished = 1;
        summary();
        $finish;
    end
endmodule